// File: doc/BRIEF.md
# Device Configuration Register Controller

This block sits between a host configuration port and a device. The host issues single-cycle read or write strobes with a 32-bit address and write data. Every access is answered with exactly one acknowledge or negative-acknowledge pulse. When the build has raw registers, addresses below 0x8000 are forwarded to an external raw-register port over a request/done handshake. The block holds a small bank of managed registers, starting with the ENABLE register. That bank begins at 0x8000 when raw registers exist and at 0 when they do not. Consecutive managed registers take consecutive addresses.

Each managed register has two copies. The staged copy takes host writes at once and is what reads return. The active copy drives the device and changes only at a soft reset. A per-register keep mask decides what a soft reset does to each register: keep it and promote the staged value, or return both copies to the power-on value. The active ENABLE bit gates the device's data-valid output. In a build for a device that produces no data, ENABLE is read-only zero and any write to it is refused.

Top module: `cfg_reg_ctrl`

## Requirements
- R1: After hard reset, managed register i holds i*0x01010101 in both the staged and the active copy. ENABLE (index 0) is masked to bit 0, so it holds 0.
- R2: A write to a managed register is acknowledged. A read of that register issued afterwards returns the written value, masked as in R5.
- R3: The active copy of a managed register does not change between soft resets. At a soft reset, a register whose keep-mask bit is 1 loads its active copy from its staged copy. The staged copy of such a register stays as it is.
- R4: At a soft reset, a register whose keep-mask bit is 0 returns both copies to its power-on value. With the default mask 4'b1011, only index 2 is cleared.
- R5: Bits 31 to 1 of ENABLE always read 0, and writes to those bits are ignored.
- R6: The data-valid output equals the data-valid input ANDed with bit 0 of the active ENABLE copy.
- R7: When raw registers exist, an access to an address of 0x7FFF or below raises the raw request. The raw request carries the low 15 address bits, the write flag and the write data. The access is acknowledged in the cycle after the port's done pulse, and a raw read returns the port's read data. An access to 0x8000 or above never raises the raw request.
- R8: An access that is neither in the raw window nor on a managed register gets a negative acknowledge and changes no register.
- R9: Every access produces exactly one response pulse, either acknowledge or negative acknowledge, never both. A managed access responds in the cycle after its strobe.
- R10: With no raw registers and no data production, ENABLE sits at address 0 and reads 0. A write to ENABLE gets a negative acknowledge. The data-valid output stays 0 even after a soft reset. Address 0x8000 gets a negative acknowledge in this build.
- R11: A write in the same cycle as a soft reset updates the staged copy. The active copy takes the staged value from before that cycle, or the power-on value if the register is cleared.
- R12: Asserting the read and write strobes together gives a negative acknowledge and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hardRstN | input | 1 | Asynchronous active-low hard reset |
| softRst | input | 1 | Synchronous soft reset pulse |
| cfgAddr | input | 32 | Access address |
| cfgWrData | input | 32 | Write data |
| cfgWrStb | input | 1 | Write strobe, one cycle |
| cfgRdStb | input | 1 | Read strobe, one cycle |
| cfgRdData | output | 32 | Read data, valid with acknowledge |
| cfgAck | output | 1 | Acknowledge pulse |
| cfgNack | output | 1 | Negative acknowledge pulse |
| rawReq | output | 1 | Raw access pending |
| rawWe | output | 1 | Raw access is a write |
| rawAddr | output | 15 | Raw register address |
| rawWrData | output | 32 | Raw write data |
| rawRdData | input | 32 | Raw read data, valid with done |
| rawDone | input | 1 | Raw access completed |
| devDataValidIn | input | 1 | Device data-valid before gating |
| devDataValidOut | output | 1 | Gated data-valid |
| activeRegs | output | 128 | Active copies, register i at bits 32*i+31:32*i |

## Verification
A host write and a soft reset can land in the same clock edge. For the same register, the write changes the staged copy while the soft reset promotes or clears it. The bench provokes this by raising the soft reset in the same cycle as a write strobe to a kept register, to the cleared register and to ENABLE. It then reads the staged value back and inspects the active outputs and the gated data-valid output. The expected result is that the write wins the staged copy and the active copy takes the value staged before that edge (or the power-on value), and the bench judges the outcome against that rule.

// File: rtl/cfg_reg_pkg.sv
package cfg_reg_pkg;
  localparam int unsigned WORD_W = 32;

  typedef struct packed {
    logic wrMgd;
    logic rdMgd;
    logic rawStart;
    logic rawCapture;
    logic respAck;
    logic respNack;
  } ctrlStb_t;

  function automatic logic [WORD_W-1:0] pwrOnValue(input int unsigned idx);
    return WORD_W'(idx) * 32'h0101_0101;
  endfunction
endpackage

// File: rtl/cfg_reg_fsm.sv
module cfg_reg_fsm
  import cfg_reg_pkg::*;
#(
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned RAW_AW        = 15,
  parameter int unsigned NUM_MGD       = 4,
  parameter int unsigned HAS_RAW       = 1,
  parameter int unsigned PRODUCES_DATA = 1,
  parameter int unsigned IDX_W         = 2
) (
  input  logic              clk,
  input  logic              hardRstN,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              cfgWrStb,
  input  logic              cfgRdStb,
  input  logic              rawDone,
  output logic              rawReq,
  output ctrlStb_t          stb,
  output logic [IDX_W-1:0]  mgdIdx
);
  localparam logic [ADDR_W-1:0] MGD_BASE =
    (HAS_RAW != 0) ? (ADDR_W'(1) << RAW_AW) : '0;
  localparam logic ENABLE_WRITABLE = (PRODUCES_DATA != 0);

  typedef enum logic {ST_IDLE, ST_RAW} state_t;
  state_t stateQ, stateD;

  logic              inRaw;
  logic              hitMgd;
  logic [ADDR_W-1:0] offset;

  generate
    if (HAS_RAW != 0) begin : g_raw
      assign inRaw = cfgAddr < MGD_BASE;
    end else begin : g_noRaw
      assign inRaw = 1'b0;
    end
  endgenerate

  assign offset = cfgAddr - MGD_BASE;
  assign hitMgd = !inRaw && (offset < ADDR_W'(NUM_MGD));
  assign mgdIdx = offset[IDX_W-1:0];

  always_comb begin
    stb    = '0;
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (cfgWrStb && cfgRdStb) begin
          stb.respNack = 1'b1;
        end else if (cfgWrStb || cfgRdStb) begin
          if (inRaw) begin
            stb.rawStart = 1'b1;
            stateD       = ST_RAW;
          end else if (hitMgd) begin
            if (cfgWrStb && (mgdIdx == '0) && !ENABLE_WRITABLE) begin
              stb.respNack = 1'b1;
            end else begin
              stb.wrMgd   = cfgWrStb;
              stb.rdMgd   = cfgRdStb;
              stb.respAck = 1'b1;
            end
          end else begin
            stb.respNack = 1'b1;
          end
        end
      end
      ST_RAW: begin
        if (rawDone) begin
          stb.rawCapture = 1'b1;
          stb.respAck    = 1'b1;
          stateD         = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) stateQ <= ST_IDLE;
    else           stateQ <= stateD;
  end

  assign rawReq = (stateQ == ST_RAW);

  // A raw request only starts from a strobe whose address lay in the raw window
  assert_raw_from_window_R7: assert property (@(posedge clk) disable iff (!hardRstN)
    $rose(rawReq) |-> $past((cfgWrStb || cfgRdStb) && (cfgAddr < MGD_BASE)));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_reg_pkg::*;
#(
  parameter int unsigned           NUM_MGD       = 4,
  parameter int unsigned           IDX_W         = 2,
  parameter int unsigned           RAW_AW        = 15,
  parameter int unsigned           PRODUCES_DATA = 1,
  parameter logic [NUM_MGD-1:0]    KEEP_MASK     = 4'b1011
) (
  input  logic                        clk,
  input  logic                        hardRstN,
  input  logic                        softRst,
  input  ctrlStb_t                    stb,
  input  logic [IDX_W-1:0]            mgdIdx,
  input  logic [RAW_AW-1:0]           cfgAddrLow,
  input  logic [WORD_W-1:0]           cfgWrData,
  input  logic                        cfgWrStb,
  input  logic [WORD_W-1:0]           rawRdData,
  input  logic                        devDataValidIn,
  output logic [WORD_W-1:0]           cfgRdData,
  output logic                        cfgAck,
  output logic                        cfgNack,
  output logic                        rawWe,
  output logic [RAW_AW-1:0]           rawAddr,
  output logic [WORD_W-1:0]           rawWrData,
  output logic [NUM_MGD*WORD_W-1:0]   activeRegs,
  output logic                        devDataValidOut
);
  logic [WORD_W-1:0]         stagedQ [NUM_MGD];
  logic [WORD_W-1:0]         activeQ [NUM_MGD];
  logic [NUM_MGD*WORD_W-1:0] stagedFlat;

  generate
    for (genvar i = 0; i < NUM_MGD; i++) begin : g_reg
      localparam logic [WORD_W-1:0] FIELD_MASK = (i == 0) ? 32'h1 : '1;
      localparam logic [WORD_W-1:0] PWR_VAL    = pwrOnValue(i) & FIELD_MASK;
      localparam logic              WRITABLE   = (i != 0) || (PRODUCES_DATA != 0);
      localparam logic              KEEP       = KEEP_MASK[i];

      always_ff @(posedge clk or negedge hardRstN) begin
        if (!hardRstN) begin
          stagedQ[i] <= PWR_VAL;
          activeQ[i] <= PWR_VAL;
        end else begin
          if (softRst) begin
            activeQ[i] <= KEEP ? stagedQ[i] : PWR_VAL;
            if (!KEEP) stagedQ[i] <= PWR_VAL;
          end
          if (WRITABLE && stb.wrMgd && (mgdIdx == IDX_W'(i)))
            stagedQ[i] <= cfgWrData & FIELD_MASK;
        end
      end

      assign activeRegs[i*WORD_W +: WORD_W] = activeQ[i];
      assign stagedFlat[i*WORD_W +: WORD_W] = stagedQ[i];
    end

    if (PRODUCES_DATA != 0) begin : g_gate
      assign devDataValidOut = devDataValidIn & activeQ[0][0];
    end else begin : g_noData
      assign devDataValidOut = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      cfgAck    <= 1'b0;
      cfgNack   <= 1'b0;
      cfgRdData <= '0;
      rawWe     <= 1'b0;
      rawAddr   <= '0;
      rawWrData <= '0;
    end else begin
      cfgAck  <= stb.respAck;
      cfgNack <= stb.respNack;
      if (stb.rdMgd)
        cfgRdData <= stagedQ[mgdIdx];
      else if (stb.rawCapture && !rawWe)
        cfgRdData <= rawRdData;
      if (stb.rawStart) begin
        rawWe     <= cfgWrStb;
        rawAddr   <= cfgAddrLow;
        rawWrData <= cfgWrData;
      end
    end
  end

  // Active copies move only on a soft reset edge
  assert_active_hold_R3: assert property (@(posedge clk) disable iff (!hardRstN)
    !softRst |=> $stable(activeRegs));

  // A refused access leaves every staged copy untouched
  assert_nack_no_write_R8: assert property (@(posedge clk) disable iff (!hardRstN)
    (cfgNack && !$past(softRst)) |-> $stable(stagedFlat));

  // Never both response kinds at once
  assert_single_resp_R9: assert property (@(posedge clk) disable iff (!hardRstN)
    !(cfgAck && cfgNack));

  // Response pulses last one cycle
  assert_resp_pulse_R9: assert property (@(posedge clk) disable iff (!hardRstN)
    (cfgAck || cfgNack) |=> !(cfgAck || cfgNack));
endmodule

// File: rtl/cfg_reg_ctrl.sv
module cfg_reg_ctrl
  import cfg_reg_pkg::*;
#(
  parameter int unsigned        ADDR_W        = 32,
  parameter int unsigned        RAW_AW        = 15,
  parameter int unsigned        NUM_MGD       = 4,
  parameter int unsigned        HAS_RAW       = 1,
  parameter int unsigned        PRODUCES_DATA = 1,
  parameter logic [NUM_MGD-1:0] KEEP_MASK     = 4'b1011
) (
  input  logic                      clk,
  input  logic                      hardRstN,
  input  logic                      softRst,
  input  logic [ADDR_W-1:0]         cfgAddr,
  input  logic [WORD_W-1:0]         cfgWrData,
  input  logic                      cfgWrStb,
  input  logic                      cfgRdStb,
  output logic [WORD_W-1:0]         cfgRdData,
  output logic                      cfgAck,
  output logic                      cfgNack,
  output logic                      rawReq,
  output logic                      rawWe,
  output logic [RAW_AW-1:0]         rawAddr,
  output logic [WORD_W-1:0]         rawWrData,
  input  logic [WORD_W-1:0]         rawRdData,
  input  logic                      rawDone,
  input  logic                      devDataValidIn,
  output logic                      devDataValidOut,
  output logic [NUM_MGD*WORD_W-1:0] activeRegs
);
  localparam int unsigned IDX_W = (NUM_MGD > 1) ? $clog2(NUM_MGD) : 1;

  ctrlStb_t         stb;
  logic [IDX_W-1:0] mgdIdx;

  cfg_reg_fsm #(
    .ADDR_W(ADDR_W), .RAW_AW(RAW_AW), .NUM_MGD(NUM_MGD),
    .HAS_RAW(HAS_RAW), .PRODUCES_DATA(PRODUCES_DATA), .IDX_W(IDX_W)
  ) fsm_i (
    .clk(clk), .hardRstN(hardRstN), .cfgAddr(cfgAddr),
    .cfgWrStb(cfgWrStb), .cfgRdStb(cfgRdStb), .rawDone(rawDone),
    .rawReq(rawReq), .stb(stb), .mgdIdx(mgdIdx)
  );

  cfg_reg_bank #(
    .NUM_MGD(NUM_MGD), .IDX_W(IDX_W), .RAW_AW(RAW_AW),
    .PRODUCES_DATA(PRODUCES_DATA), .KEEP_MASK(KEEP_MASK)
  ) bank_i (
    .clk(clk), .hardRstN(hardRstN), .softRst(softRst), .stb(stb),
    .mgdIdx(mgdIdx), .cfgAddrLow(cfgAddr[RAW_AW-1:0]), .cfgWrData(cfgWrData),
    .cfgWrStb(cfgWrStb), .rawRdData(rawRdData), .devDataValidIn(devDataValidIn),
    .cfgRdData(cfgRdData), .cfgAck(cfgAck), .cfgNack(cfgNack),
    .rawWe(rawWe), .rawAddr(rawAddr), .rawWrData(rawWrData),
    .activeRegs(activeRegs), .devDataValidOut(devDataValidOut)
  );
endmodule

// File: tb/cfg_reg_ctrl_tb_top.sv
module cfg_reg_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic hardRstN = 1'b0, softRst = 1'b0, cfgWrStb = 1'b0, cfgRdStb = 1'b0, validIn = 1'b0;
  logic [31:0] cfgAddr = '0, cfgWrData = '0;

  logic [31:0] rdA, rawWrA, rawRdA;
  logic ackA, nackA, rawReqA, rawWeA, validOutA;
  logic rawDoneA = 1'b0;
  logic [14:0] rawAddrA;
  logic [127:0] activeA;

  logic [31:0] rdB, rawWrB;
  logic ackB, nackB, rawReqB, rawWeB, validOutB;
  logic [14:0] rawAddrB;
  logic [63:0] activeB;

  cfg_reg_ctrl dut_i (
    .clk(clk), .hardRstN(hardRstN), .softRst(softRst), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgWrStb(cfgWrStb), .cfgRdStb(cfgRdStb),
    .cfgRdData(rdA), .cfgAck(ackA), .cfgNack(nackA), .rawReq(rawReqA),
    .rawWe(rawWeA), .rawAddr(rawAddrA), .rawWrData(rawWrA), .rawRdData(rawRdA),
    .rawDone(rawDoneA), .devDataValidIn(validIn), .devDataValidOut(validOutA),
    .activeRegs(activeA));

  cfg_reg_ctrl #(.NUM_MGD(2), .HAS_RAW(0), .PRODUCES_DATA(0), .KEEP_MASK(2'b01)) dutB_i (
    .clk(clk), .hardRstN(hardRstN), .softRst(softRst), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgWrStb(cfgWrStb), .cfgRdStb(cfgRdStb),
    .cfgRdData(rdB), .cfgAck(ackB), .cfgNack(nackB), .rawReq(rawReqB),
    .rawWe(rawWeB), .rawAddr(rawAddrB), .rawWrData(rawWrB), .rawRdData(32'h0),
    .rawDone(1'b0), .devDataValidIn(validIn), .devDataValidOut(validOutB),
    .activeRegs(activeB));

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pwr(input int i);
    return (i == 0) ? 32'h0 : 32'(i) * 32'h0101_0101;
  endfunction

  function automatic logic [31:0] fmask(input int i);
    return (i == 0) ? 32'h1 : 32'hFFFF_FFFF;
  endfunction

  // Raw port model: done two cycles after request
  logic [31:0] rawMem [32];
  int rawCount = 0, rawWait = 0;
  logic [14:0] lastRawAddr = '0;
  initial for (int k = 0; k < 32; k++) rawMem[k] = 32'h5A00_0000 | 32'(k);
  always @(negedge clk) begin
    if (rawReqA && !rawDoneA) begin
      rawWait++;
      if (rawWait == 2) begin
        rawWait = 0;
        rawDoneA = 1'b1;
        rawCount++;
        lastRawAddr = rawAddrA;
        rawRdA = rawMem[rawAddrA[4:0]];
        if (rawWeA) rawMem[rawAddrA[4:0]] = rawWrA;
      end
    end else begin
      rawDoneA = 1'b0;
    end
  end

  logic aAck, aNack, bAck, bNack;
  logic [31:0] aData, bData;
  int aLat;

  task automatic access(input logic [31:0] addr, input logic we, input logic re,
                        input logic [31:0] wdata, input logic withSoft);
    int pulsesA, pulsesB;
    @(negedge clk);
    cfgAddr = addr; cfgWrData = wdata; cfgWrStb = we; cfgRdStb = re; softRst = withSoft;
    @(negedge clk);
    cfgWrStb = 1'b0; cfgRdStb = 1'b0; softRst = 1'b0;
    bAck = ackB; bNack = nackB; bData = rdB;
    pulsesB = int'(ackB) + int'(nackB);
    aLat = 0;
    while (!(ackA || nackA) && aLat < 50) begin @(negedge clk); aLat++; end
    aAck = ackA; aNack = nackA; aData = rdA;
    pulsesA = int'(ackA) + int'(nackA);
    @(negedge clk);
    pulsesA += int'(ackA) + int'(nackA);
    pulsesB += int'(ackB) + int'(nackB);
    chk("R9 pulses A", 32'(pulsesA), 32'd1);
    chk("R9 pulses B", 32'(pulsesB), 32'd1);
    if (addr >= 32'h8000) chk("R9 managed latency", 32'(aLat), 32'd0);
  endtask

  task automatic rdA_chk(input int i, input logic [31:0] exp, input string req);
    access(32'h8000 + 32'(i), 1'b0, 1'b1, 32'h0, 1'b0);
    chk(req, {30'h0, aAck, aNack}, 32'h2);
    chk(req, aData, exp);
  endtask

  task automatic softPulse();
    @(negedge clk); softRst = 1'b1;
    @(negedge clk); softRst = 1'b0;
  endtask

  task automatic hardReset();
    @(negedge clk); hardRstN = 1'b0;
    @(negedge clk); @(negedge clk); hardRstN = 1'b1;
  endtask

  logic [31:0] pats [4];
  logic [31:0] sticky [NREG];

  initial begin
    int rc;
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_5A5A; pats[2] = 32'h0; pats[3] = 32'h1234_5679;
    validIn = 1'b1;
    hardReset();
    // R1 reset state
    chk("R6 validOut after reset", {31'h0, validOutA}, 32'h0);
    for (int i = 0; i < NREG; i++) begin
      chk("R1 active at reset", activeA[i*32 +: 32], pwr(i));
      rdA_chk(i, pwr(i), "R1 staged at reset");
      if (i == 0) chk("R10 addr 0x8000 nack in no-raw build", {30'h0, bAck, bNack}, 32'h1);
    end
    // R2/R5/R3 write sweep
    rc = rawCount;
    foreach (pats[p]) begin
      for (int i = 0; i < NREG; i++) begin
        access(32'h8000 + 32'(i), 1'b1, 1'b0, pats[p] ^ 32'(i), 1'b0);
        chk("R2 write ack", {30'h0, aAck, aNack}, 32'h2);
        rdA_chk(i, (pats[p] ^ 32'(i)) & fmask(i), (i == 0) ? "R5 enable masked" : "R2 readback");
        chk("R3 active held", activeA[i*32 +: 32], pwr(i));
        sticky[i] = (pats[p] ^ 32'(i)) & fmask(i);
      end
    end
    chk("R7 no raw request for managed", 32'(rawCount), 32'(rc));
    chk("R6 enable staged only", {31'h0, validOutA}, 32'h0);
    // soft reset: R3 / R4 / R6
    softPulse();
    @(negedge clk);
    for (int i = 0; i < NREG; i++) begin
      logic [31:0] e;
      e = (i == 2) ? pwr(2) : sticky[i];
      chk((i == 2) ? "R4 cleared active" : "R3 kept active", activeA[i*32 +: 32], e);
      rdA_chk(i, e, (i == 2) ? "R4 cleared staged" : "R3 kept staged");
      sticky[i] = e;
    end
    validIn = 1'b1; #1;
    chk("R6 gated on", {31'h0, validOutA}, 32'h1);
    validIn = 1'b0; #1;
    chk("R6 gated input low", {31'h0, validOutA}, 32'h0);
    validIn = 1'b1;
    // R8 unmapped
    access(32'h8004, 1'b0, 1'b1, 32'h0, 1'b0);
    chk("R8 read unmapped nack", {30'h0, aAck, aNack}, 32'h1);
    chk("R10 unmapped nack B", {30'h0, bAck, bNack}, 32'h1);
    access(32'h8004, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0);
    chk("R8 write unmapped nack", {30'h0, aAck, aNack}, 32'h1);
    access(32'hFFFF_FFFF, 1'b1, 1'b0, 32'h0, 1'b0);
    chk("R8 top address nack", {30'h0, aAck, aNack}, 32'h1);
    // R12 both strobes
    access(32'h8001, 1'b1, 1'b1, 32'hDEAD_BEEF, 1'b0);
    chk("R12 both strobes nack", {30'h0, aAck, aNack}, 32'h1);
    for (int i = 0; i < NREG; i++) rdA_chk(i, sticky[i], "R8 R12 no change");
    // R7 raw window
    access(32'h0000_0005, 1'b1, 1'b0, 32'hDEAD_0005, 1'b0);
    chk("R7 raw write ack", {30'h0, aAck, aNack}, 32'h2);
    chk("R7 raw addr", {17'h0, lastRawAddr}, 32'h5);
    chk("R7 raw waited", 32'(aLat >= 2), 32'h1);
    access(32'h0000_0005, 1'b0, 1'b1, 32'h0, 1'b0);
    chk("R7 raw readback", aData, 32'hDEAD_0005);
    access(32'h0000_7FFF, 1'b1, 1'b0, 32'hCAFE_7FFF, 1'b0);
    chk("R7 raw top addr", {17'h0, lastRawAddr}, 32'h7FFF);
    access(32'h0000_7FFF, 1'b0, 1'b1, 32'h0, 1'b0);
    chk("R7 raw top readback", aData, 32'hCAFE_7FFF);
    chk("R10 raw addr nack B", {30'h0, bAck, bNack}, 32'h1);
    access(32'h0000_0003, 1'b0, 1'b1, 32'h0, 1'b0);
    chk("R7 raw untouched word", aData, 32'h5A00_0003);
    // R11 soft reset with write
    access(32'h8003, 1'b1, 1'b0, 32'h55, 1'b0);
    access(32'h8003, 1'b1, 1'b0, 32'h77, 1'b1);
    chk("R11 active takes old staged", activeA[3*32 +: 32], 32'h55);
    rdA_chk(3, 32'h77, "R11 staged takes write");
    access(32'h8002, 1'b1, 1'b0, 32'h99, 1'b1);
    chk("R11 cleared active power-on", activeA[2*32 +: 32], pwr(2));
    rdA_chk(2, 32'h99, "R11 write wins clear");
    chk("R11 kept promoted", activeA[3*32 +: 32], 32'h77);
    access(32'h8000, 1'b1, 1'b0, 32'h0, 1'b1);
    chk("R11 enable active keeps 1", {31'h0, validOutA}, 32'h1);
    rdA_chk(0, 32'h0, "R11 enable staged 0");
    softPulse();
    @(negedge clk);
    chk("R6 disabled after soft reset", {31'h0, validOutA}, 32'h0);
    chk("R4 cleared again", activeA[2*32 +: 32], pwr(2));
    rdA_chk(2, pwr(2), "R4 staged cleared");
    // R10 no-raw no-data build
    access(32'h0, 1'b0, 1'b1, 32'h0, 1'b0);
    chk("R10 enable read ack", {30'h0, bAck, bNack}, 32'h2);
    chk("R10 enable reads 0", bData, 32'h0);
    access(32'h0, 1'b1, 1'b0, 32'h1, 1'b0);
    chk("R10 enable write nack", {30'h0, bAck, bNack}, 32'h1);
    access(32'h0, 1'b0, 1'b1, 32'h0, 1'b0);
    chk("R10 enable still 0", bData, 32'h0);
    access(32'h1, 1'b0, 1'b1, 32'h0, 1'b0);
    chk("R10 reg1 at addr 1", bData, 32'h0101_0101);
    access(32'h1, 1'b1, 1'b0, 32'h0BAD_F00D, 1'b0);
    access(32'h1, 1'b0, 1'b1, 32'h0, 1'b0);
    chk("R10 reg1 readback", bData, 32'h0BAD_F00D);
    access(32'h2, 1'b0, 1'b1, 32'h0, 1'b0);
    chk("R10 addr 2 nack", {30'h0, bAck, bNack}, 32'h1);
    softPulse();
    @(negedge clk);
    chk("R10 validOut stays 0", {31'h0, validOutB}, 32'h0);
    chk("R10 enable active 0", activeB[31:0], 32'h0);
    // R1 hard reset after writes
    hardReset();
    for (int i = 0; i < NREG; i++) begin
      chk("R1 active after hard reset", activeA[i*32 +: 32], pwr(i));
      rdA_chk(i, pwr(i), "R1 staged after hard reset");
    end
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule